// File: doc/BRIEF.md
# Switch Input Flow-Control Violation Checker

This block sits beside the input stage of a packet switch and watches every packet that arrives. An arrival is a violation when the shared store has no free address to take it. When a host-set check mode is on, an arrival is also a violation if it targets any output that has not been granted within the last eight packet cycles. Every output keeps its own age counter. The counter counts packet-cycle ticks since that output's last grant and stops at the window length.

Each cycle that contains at least one violation produces a single-cycle event pulse. The status logic outside this block turns that pulse into a maskable interrupt status bit. Two sticky logs record what went wrong, and the host reads them and clears them with a clear strobe. The first log holds the input ports that carried offending packets. The second holds the stale destination outputs that caused grant-window violations. The store manager, the scheduler and the grant generator are outside this block.

Top module: `fcv_top`

## Requirements
- R1: After reset the pulse and both logs are 0, and every output counts as stale: its age starts saturated, as if no grant had ever been seen.
- R2: An arrival on input i (`arr_vld[i]`=1) while `pool_empty`=1 is a violation whatever the state of `chk_en`. `viol_pulse` is 1 in the following cycle and bit i of `viol_ports` is set.
- R3: With `chk_en`=1, an arrival whose destination mask (bits `arr_dest[i*N_OUT +: N_OUT]` for input i, bit j meaning output j) includes a stale output is a violation.
- R4: A grant to output j (`out_grant[j]`=1) sets its age to 0 and takes priority over a tick in the same cycle. Each later cycle with `pkt_tick`=1 adds one to the age. The output is stale once its age reaches 8, which is after the eighth tick. A grant in the same cycle as an arrival does not count for that arrival.
- R5: The age saturates at 8. Any number of further ticks leaves the output stale and never wraps it back to fresh.
- R6: With `chk_en`=0, stale destinations cause no violation. Only the empty-store check applies.
- R7: `viol_ports` and `viol_outs` accumulate by bitwise OR across violations and hold their value until cleared.
- R8: `log_clr`=1 zeroes both logs in the next cycle. Bits from violations in the same cycle as the clear are kept.
- R9: `viol_outs` gains, for each arrival while `chk_en`=1, the bits of its destination mask that are stale. Nothing is added while `chk_en`=0.
- R10: Several inputs violating in one cycle set each of their bits. An arrival with an empty destination mask, while the store is not empty, is never a violation.
- R11: `viol_pulse` is high for exactly those cycles that follow a cycle with at least one violation. It is never stretched and never high after a cycle with no arrivals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arr_vld | input | N_IN | Per-input packet arrival strobe |
| arr_dest | input | N_IN*N_OUT | Destination masks, N_OUT bits per input |
| pool_empty | input | 1 | No free store address this cycle |
| out_grant | input | N_OUT | Per-output grant strobe |
| pkt_tick | input | 1 | Packet-cycle tick that ages all outputs |
| chk_en | input | 1 | Enables the grant-window check |
| log_clr | input | 1 | Host clear of both logs |
| viol_pulse | output | 1 | One-cycle violation event |
| viol_ports | output | N_IN | Sticky log of offending inputs |
| viol_outs | output | N_OUT | Sticky log of stale destination outputs |

## Verification
The bench targets the edge of the eight-tick window: an arrival after seven ticks must pass and one after eight must not. A design that is off by one either raises false alarms or misses late packets. It checks that a grant beats a tick in the same cycle, and that a same-cycle grant does not rescue the arrival. It drives long idle stretches to catch a counter that wraps back to fresh. A clear is issued together with a new violation; a design that lets the clear win loses the event. Arrivals with the check mode off confirm that stale outputs alone never flag anything.

// File: rtl/fcv_pkg.sv
package fcv_pkg;

  // Next age of one output's grant counter.
  // grant wins over tick; the age stops at the window length.
  function automatic int unsigned age_next(int unsigned age, logic grant,
                                           logic tick, int unsigned window);
    if (grant)
      return 0;
    else if (tick && age < window)
      return age + 1;
    else
      return age;
  endfunction

  // An output is stale once its age has reached the window length.
  function automatic logic is_stale(int unsigned age, int unsigned window);
    return age >= window;
  endfunction

  // One input's verdict for one cycle.
  function automatic logic arrival_bad(logic vld, logic empty, logic chk,
                                       logic late);
    return vld && (empty || (chk && late));
  endfunction

endpackage

// File: rtl/fcv_grant_age.sv
module fcv_grant_age #(
  parameter int N_OUT  = 16,
  parameter int WINDOW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_OUT-1:0] grant,
  input  logic             tick,
  output logic [N_OUT-1:0] stale
);
  localparam int AW = $clog2(WINDOW + 1);
  localparam logic [AW-1:0] AGE_MAX = AW'(WINDOW);

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    logic [AW-1:0] age_q;
    logic [AW-1:0] age_d;

    assign age_d = AW'(fcv_pkg::age_next(int'(age_q), grant[j], tick, WINDOW));
    assign stale[j] = fcv_pkg::is_stale(int'(age_q), WINDOW);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) age_q <= AGE_MAX;
      else        age_q <= age_d;
    end
  end
endmodule

// File: rtl/fcv_detect.sv
module fcv_detect #(
  parameter int N_IN  = 16,
  parameter int N_OUT = 16
) (
  input  logic [N_IN-1:0]       arr_vld,
  input  logic [N_IN*N_OUT-1:0] arr_dest,
  input  logic                  pool_empty,
  input  logic                  chk_en,
  input  logic [N_OUT-1:0]      stale,
  output logic [N_IN-1:0]       bad_in,
  output logic [N_OUT-1:0]      late_out
);
  logic [N_OUT-1:0] late_hit [N_IN];

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    logic [N_OUT-1:0] dest;
    assign dest        = arr_dest[i*N_OUT +: N_OUT];
    assign late_hit[i] = (arr_vld[i] && chk_en) ? (dest & stale) : '0;
    assign bad_in[i]   = fcv_pkg::arrival_bad(arr_vld[i], pool_empty, chk_en,
                                              |(dest & stale));
  end

  always_comb begin
    late_out = '0;
    for (int i = 0; i < N_IN; i++)
      late_out = late_out | late_hit[i];
  end
endmodule

// File: rtl/fcv_log.sv
module fcv_log #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] set,
  output logic [W-1:0] q
);
  // set has priority over a simultaneous clear so no event is lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (clr ? '0 : q) | set;
  end
endmodule

// File: rtl/fcv_top.sv
module fcv_top #(
  parameter int N_IN   = 16,
  parameter int N_OUT  = 16,
  parameter int WINDOW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_IN-1:0]       arr_vld,
  input  logic [N_IN*N_OUT-1:0] arr_dest,
  input  logic                  pool_empty,
  input  logic [N_OUT-1:0]      out_grant,
  input  logic                  pkt_tick,
  input  logic                  chk_en,
  input  logic                  log_clr,
  output logic                  viol_pulse,
  output logic [N_IN-1:0]       viol_ports,
  output logic [N_OUT-1:0]      viol_outs
);
  logic [N_OUT-1:0] stale_vec;
  logic [N_IN-1:0]  viol_now;
  logic [N_OUT-1:0] late_now;

  fcv_grant_age #(.N_OUT(N_OUT), .WINDOW(WINDOW)) u_age (
    .clk   (clk),
    .rst_n (rst_n),
    .grant (out_grant),
    .tick  (pkt_tick),
    .stale (stale_vec)
  );

  fcv_detect #(.N_IN(N_IN), .N_OUT(N_OUT)) u_det (
    .arr_vld    (arr_vld),
    .arr_dest   (arr_dest),
    .pool_empty (pool_empty),
    .chk_en     (chk_en),
    .stale      (stale_vec),
    .bad_in     (viol_now),
    .late_out   (late_now)
  );

  fcv_log #(.W(N_IN)) u_port_log (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (log_clr),
    .set   (viol_now),
    .q     (viol_ports)
  );

  fcv_log #(.W(N_OUT)) u_out_log (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (log_clr),
    .set   (late_now),
    .q     (viol_outs)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_pulse <= 1'b0;
    else        viol_pulse <= |viol_now;
  end
endmodule

// File: rtl/fcv_checker.sv
module fcv_checker #(
  parameter int N_IN  = 16,
  parameter int N_OUT = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_IN-1:0]  arr_vld,
  input logic             pool_empty,
  input logic [N_OUT-1:0] out_grant,
  input logic             log_clr,
  input logic             viol_pulse,
  input logic [N_IN-1:0]  viol_ports,
  input logic [N_IN-1:0]  viol_now,
  input logic [N_OUT-1:0] stale_vec
);
  p_exhaust_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|arr_vld && pool_empty) |=> viol_pulse);

  p_exhaust_log_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pool_empty |=> ((viol_ports & $past(arr_vld)) == $past(arr_vld)));

  p_grant_fresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_grant) |=> ((stale_vec & $past(out_grant)) == '0));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(|arr_vld) |=> !viol_pulse);

  p_ports_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !log_clr |=> ((viol_ports & $past(viol_ports)) == $past(viol_ports)));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (log_clr && !(|viol_now)) |=> (viol_ports == '0));

  p_pulse_logged_r11: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> (viol_ports != '0));
endmodule

bind fcv_top fcv_checker #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .arr_vld    (arr_vld),
  .pool_empty (pool_empty),
  .out_grant  (out_grant),
  .log_clr    (log_clr),
  .viol_pulse (viol_pulse),
  .viol_ports (viol_ports),
  .viol_now   (viol_now),
  .stale_vec  (stale_vec)
);

// File: tb/tb_fcv_top.sv
`timescale 1ns/1ps
module tb_fcv_top;
  localparam int NI = 16;
  localparam int NO = 16;
  localparam int WIN = 8;

  logic            clk = 0;
  logic            rst_n = 0;
  logic [NI-1:0]   arr_vld = '0;
  logic [NI*NO-1:0] arr_dest = '0;
  logic            pool_empty = 0;
  logic [NO-1:0]   out_grant = '0;
  logic            pkt_tick = 0;
  logic            chk_en = 0;
  logic            log_clr = 0;
  logic            viol_pulse;
  logic [NI-1:0]   viol_ports;
  logic [NO-1:0]   viol_outs;

  int vectors = 0;
  int errors = 0;
  string phase = "R1";

  // reference state
  int        ref_age [NO];
  bit        ref_pulse;
  bit [NI-1:0] ref_ports;
  bit [NO-1:0] ref_outs;

  always #4 clk = ~clk;

  fcv_top #(.N_IN(NI), .N_OUT(NO), .WINDOW(WIN)) dut (
    .clk, .rst_n, .arr_vld, .arr_dest, .pool_empty, .out_grant,
    .pkt_tick, .chk_en, .log_clr, .viol_pulse, .viol_ports, .viol_outs
  );

  task automatic model_step();
    bit [NI-1:0] np;
    bit [NO-1:0] no;
    if (!rst_n) begin
      foreach (ref_age[j]) ref_age[j] = WIN;
      ref_pulse = 0; ref_ports = '0; ref_outs = '0;
      return;
    end
    np = '0; no = '0;
    for (int i = 0; i < NI; i++) begin
      if (arr_vld[i]) begin
        bit late = 0;
        for (int j = 0; j < NO; j++)
          if (arr_dest[i*NO+j] && ref_age[j] >= WIN) begin
            late = 1;
            if (chk_en) no[j] = 1;
          end
        if (pool_empty || (chk_en && late)) np[i] = 1;
      end
    end
    ref_pulse = (np != '0);
    ref_ports = (log_clr ? '0 : ref_ports) | np;
    ref_outs  = (log_clr ? '0 : ref_outs) | no;
    for (int j = 0; j < NO; j++)
      if (out_grant[j]) ref_age[j] = 0;
      else if (pkt_tick && ref_age[j] < WIN) ref_age[j]++;
  endtask

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  // advance one clock, update the model, compare all outputs
  task automatic cyc();
    @(negedge clk);
    model_step();
    cmp("viol_pulse", 32'(viol_pulse), 32'(ref_pulse));
    cmp("viol_ports", 32'(viol_ports), 32'(ref_ports));
    cmp("viol_outs",  32'(viol_outs),  32'(ref_outs));
  endtask

  task automatic expect_bit(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic quiet();
    arr_vld = '0; arr_dest = '0; pool_empty = 0; out_grant = '0;
    pkt_tick = 0; log_clr = 0;
  endtask

  task automatic send(int i, logic [NO-1:0] dest);
    arr_vld[i] = 1'b1;
    arr_dest[i*NO +: NO] = dest;
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      quiet(); pkt_tick = 1; cyc();
    end
    quiet();
  endtask

  task automatic clear_logs();
    quiet(); log_clr = 1; cyc(); quiet(); cyc();
  endtask

  initial begin
    repeat (3) cyc();
    expect_bit("R1 pulse at reset", viol_pulse, 0);
    expect_bit("R1 ports at reset", viol_ports != '0, 0);
    rst_n = 1;
    cyc();

    // R1: every output starts stale
    phase = "R1"; chk_en = 1;
    send(0, 16'h0008); cyc(); quiet(); cyc();
    expect_bit("R1 stale after reset", viol_ports[0], 1);
    clear_logs();

    // R4: grant, then the eight-tick window edge
    phase = "R4";
    out_grant = '1; pkt_tick = 1; cyc(); quiet();
    ticks(7);
    send(3, 16'h0020); cyc(); quiet(); cyc();
    expect_bit("R4 seven ticks still fresh", viol_ports[3], 0);
    ticks(1);
    send(3, 16'h0020); cyc(); quiet();
    expect_bit("R4 eighth tick stale", viol_pulse, 1);
    cyc();
    expect_bit("R4 pulse one cycle R11", viol_pulse, 0);
    // same-cycle grant does not rescue the arrival
    send(4, 16'h0020); out_grant[5] = 1; cyc(); quiet();
    expect_bit("R4 same-cycle grant", viol_pulse, 1);
    cyc();
    send(4, 16'h0020); cyc(); quiet();
    expect_bit("R4 granted output fresh", viol_pulse, 0);

    // R5: saturation, no wrap
    phase = "R5";
    ticks(20);
    send(6, 16'h0020); cyc(); quiet();
    expect_bit("R5 saturated stays stale", viol_pulse, 1);
    cyc();
    clear_logs();

    // R6: check mode off
    phase = "R6"; chk_en = 0;
    send(1, 16'hFFFF); send(2, 16'h0001); cyc(); quiet();
    expect_bit("R6 no flag with check off", viol_pulse, 0);
    cyc();

    // R2 / R10: exhaustion, several inputs
    phase = "R2";
    pool_empty = 1; send(2, 16'h0001); send(9, 16'h0100); cyc(); quiet();
    expect_bit("R2 exhaustion pulse", viol_pulse, 1);
    expect_bit("R10 input 2 logged", viol_ports[2], 1);
    expect_bit("R10 input 9 logged", viol_ports[9], 1);
    expect_bit("R9 no outs with check off", viol_outs != '0, 0);
    cyc();

    // R10: empty destination never violates
    phase = "R10"; chk_en = 1;
    send(11, 16'h0000); cyc(); quiet();
    expect_bit("R10 empty dest", viol_pulse, 0);
    cyc();

    // R7: accumulation
    phase = "R7";
    pool_empty = 1; send(12, 16'h0000); cyc(); quiet(); cyc();
    expect_bit("R7 earlier bit held", viol_ports[9], 1);
    expect_bit("R7 new bit added", viol_ports[12], 1);

    // R9: stale outputs logged with check on
    phase = "R9";
    out_grant[0] = 1; cyc(); quiet();
    send(13, 16'h0C01); cyc(); quiet(); cyc();
    expect_bit("R9 stale out 10", viol_outs[10], 1);
    expect_bit("R9 fresh out 0 not logged", viol_outs[0], 0);

    // R8: clear with simultaneous violation
    phase = "R8";
    log_clr = 1; pool_empty = 1; send(14, 16'h0000); cyc(); quiet(); cyc();
    expect_bit("R8 concurrent bit kept", viol_ports[14], 1);
    expect_bit("R8 old bit cleared", viol_ports[9], 0);
    expect_bit("R8 outs cleared", viol_outs != '0, 0);
    clear_logs();
    expect_bit("R8 all clear", viol_ports != '0, 0);

    // R3: mixed random traffic against the model
    phase = "R3";
    for (int k = 0; k < 400; k++) begin
      arr_vld    = NI'($urandom) & NI'($urandom);
      for (int i = 0; i < NI; i++) arr_dest[i*NO +: NO] = NO'($urandom) & NO'($urandom) & NO'($urandom);
      pool_empty = ($urandom_range(0, 15) == 0);
      out_grant  = NO'($urandom) & NO'($urandom) & NO'($urandom);
      pkt_tick   = $urandom_range(0, 1);
      chk_en     = ($urandom_range(0, 3) != 0);
      log_clr    = ($urandom_range(0, 7) == 0);
      cyc();
    end
    quiet(); cyc();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule